// File: doc/BRIEF.md
# Direction-free open-drain bus repeater

This block joins two segments of a wired-AND bus, called side A and side B. Each side has one line input, which samples the wire level, and one pull-down enable output. When an outside agent pulls one side low, the block pulls the other side low too. It keeps pulling until the side that started the low lets go. After that, neither side is pulled and both float high. No direction-control input is needed: whichever side goes low first sets the direction for that transfer.

The block must not be fooled by its own pull-down. While it drives side B low, the low level it reads back on side B comes from the block itself. That level is not treated as a request to drive side A. The same holds the other way round.

Both line inputs pass through synchronisers before the control logic uses them. After a release, a short recovery window lets the far side rise and the synchronised copy of that side settle before the block accepts a new request.

Top module: `odr_link`

## Requirements
- R1: After reset, and while both lines read high and no transfer is pending, neither `pull_a_o` nor `pull_b_o` is asserted.
- R2: In the idle state, a low on side A that lasts long enough asserts `pull_b_o`. It is first seen high after SYNC_STAGES+1 rising edges counted from the first edge that samples the low; with default parameters that is the third edge.
- R3: In the idle state, a low on side B, with side A high, asserts `pull_a_o` with the same latency as R2.
- R4: Once asserted, the far-side pull-down stays asserted for as long as the originating side reads low. It deasserts SYNC_STAGES+1 rising edges after the originating side goes high.
- R5: While the block drives side B low, it never asserts `pull_a_o`, whatever level side B shows. While it drives side A low, it never asserts `pull_b_o`.
- R6: If both sides first read low on the same cycle while idle, side A wins: `pull_b_o` is asserted and `pull_a_o` is not.
- R7: After a release, the block stays in recovery for SYNC_STAGES+GUARD_CYCLES clock cycles and asserts no pull-down during that time. A low that is still present after recovery starts a new transfer; with defaults, a side-B low applied at the same moment as a side-A release gives `pull_a_o` on the seventh edge.
- R8: `pull_a_o` and `pull_b_o` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_a_i | input | 1 | Sampled level of the side-A wire (0 = low) |
| line_b_i | input | 1 | Sampled level of the side-B wire (0 = low) |
| pull_a_o | output | 1 | Pull-down enable for side A (1 = drive low) |
| pull_b_o | output | 1 | Pull-down enable for side B (1 = drive low) |

## Verification
The bench builds the block with SYNC_STAGES = 2 and GUARD_CYCLES = 1, which gives a recovery window of three cycles. These values make the full readback loop visible: the far side stays low for two edges after the block releases it, so a recovery window shorter than the synchroniser depth would turn the block's own echo into a reversed transfer. The bench closes each wire as the AND of an outside agent and the block's pull-down. That lets it exercise same-cycle starts, a new request arriving during recovery, and long sequences of pseudo-random pulses on both sides.

// File: rtl/odr_pkg.sv
package odr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_A2B     = 2'd1,
    ST_B2A     = 2'd2,
    ST_RECOVER = 2'd3
  } odr_state_e;

  // Recovery ends on the cycle whose count is the last of the window.
  function automatic logic window_last(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

endpackage

// File: rtl/odr_sync.sv
module odr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // Resets to the idle (high) bus level.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/odr_dir_fsm.sv
module odr_dir_fsm
  import odr_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int GUARD_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_low_i,
  input  logic b_low_i,
  output logic pull_a_o,
  output logic pull_b_o
);
  localparam int HOLD = SYNC_STAGES + GUARD_CYCLES;
  localparam int CW   = $clog2(HOLD + 1);

  odr_state_e       state_q, state_d;
  logic [CW-1:0]    rec_cnt_q;

  // Named events for the assertions.
  logic start_ab, start_ba, release_evt, rec_done;

  assign start_ab    = (state_q == ST_IDLE) && a_low_i;
  assign start_ba    = (state_q == ST_IDLE) && !a_low_i && b_low_i;
  assign release_evt = ((state_q == ST_A2B) && !a_low_i) ||
                       ((state_q == ST_B2A) && !b_low_i);
  assign rec_done    = (state_q == ST_RECOVER) &&
                       window_last(int'(rec_cnt_q), HOLD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ab)      state_d = ST_A2B;
        else if (start_ba) state_d = ST_B2A;
      end
      ST_A2B, ST_B2A: if (release_evt) state_d = ST_RECOVER;
      ST_RECOVER:     if (rec_done)    state_d = ST_IDLE;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rec_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_RECOVER) rec_cnt_q <= '0;
      else if (!rec_done)        rec_cnt_q <= rec_cnt_q + 1'b1;
    end
  end

  assign pull_b_o = (state_q == ST_A2B);
  assign pull_a_o = (state_q == ST_B2A);

  p_excl_pull_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pull_a_o && pull_b_o));
  p_start_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && a_low_i) |=> pull_b_o);
  p_start_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !a_low_i && b_low_i) |=> pull_a_o);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_b_o && a_low_i) |=> pull_b_o);
  p_no_reverse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_b_o |=> !pull_a_o);
  p_prio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && a_low_i && b_low_i) |=> (pull_b_o && !pull_a_o));
  p_recover_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOVER && !rec_done) |=> (!pull_a_o && !pull_b_o));
endmodule

// File: rtl/odr_link.sv
module odr_link #(
  parameter int SYNC_STAGES  = 2,
  parameter int GUARD_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_a_i,
  input  logic line_b_i,
  output logic pull_a_o,
  output logic pull_b_o
);
  localparam int SIDES = 2;

  logic [SIDES-1:0] raw_lvl, sync_lvl;

  assign raw_lvl = {line_b_i, line_a_i};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    odr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk),
      .rst_ni(rst_n),
      .d_i   (raw_lvl[s]),
      .q_o   (sync_lvl[s])
    );
  end

  odr_dir_fsm #(
    .SYNC_STAGES (SYNC_STAGES),
    .GUARD_CYCLES(GUARD_CYCLES)
  ) u_fsm (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .a_low_i (~sync_lvl[0]),
    .b_low_i (~sync_lvl[1]),
    .pull_a_o(pull_a_o),
    .pull_b_o(pull_b_o)
  );
endmodule

// File: tb/tb_odr_link.sv
`timescale 1ns/1ps
module tb_odr_link;
  localparam int SYNC  = 2;
  localparam int GUARD = 1;
  localparam int HOLD  = SYNC + GUARD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_a = 1'b0, ext_b = 1'b0;
  logic pull_a, pull_b;
  wire  line_a = ~(ext_a | pull_a);
  wire  line_b = ~(ext_b | pull_b);

  int checks = 0, errors = 0;
  bit model_on = 1'b0;

  always #10 clk = ~clk;

  odr_link #(.SYNC_STAGES(SYNC), .GUARD_CYCLES(GUARD)) dut (
    .clk(clk), .rst_n(rst_n), .line_a_i(line_a), .line_b_i(line_b),
    .pull_a_o(pull_a), .pull_b_o(pull_b));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: 0 idle, 1 A drives B, 2 B drives A, 3 recovery.
  int m_st = 0, m_cnt = 0;
  bit qa[$], qb[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; qa = {}; qb = {};
      for (int i = 0; i < SYNC; i++) begin qa.push_back(1'b1); qb.push_back(1'b1); end
    end else begin
      bit sa, sb;
      sa = qa.pop_front(); sb = qb.pop_front();
      qa.push_back(line_a); qb.push_back(line_b);
      case (m_st)
        0: if (!sa) m_st = 1; else if (!sb) m_st = 2;
        1: if (sa) begin m_st = 3; m_cnt = 0; end
        2: if (sb) begin m_st = 3; m_cnt = 0; end
        default: if (m_cnt == HOLD - 1) m_st = 0; else m_cnt++;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      string tg;
      tg = (m_st == 0) ? "R1" : (m_st == 1) ? "R2" : (m_st == 2) ? "R3" : "R7";
      chk(tg, pull_a, m_st == 2);
      chk(tg, pull_b, m_st == 1);
      chk("R8", pull_a && pull_b, 1'b0);
    end
  end

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", pull_a, 1'b0);
    chk("R1", pull_b, 1'b0);
    model_on = 1'b1;
    cyc(4);

    // R2 / R4 / R5: side A originates
    ext_a = 1'b1;
    cyc(SYNC);   chk("R2", pull_b, 1'b0);
    cyc(1);      chk("R2", pull_b, 1'b1);
    cyc(10);     chk("R5", pull_a, 1'b0); chk("R5", line_b, 1'b0);
    ext_a = 1'b0;
    cyc(SYNC);   chk("R4", pull_b, 1'b1);
    cyc(1);      chk("R4", pull_b, 1'b0); chk("R5", pull_a, 1'b0);
    cyc(HOLD);   chk("R7", pull_a, 1'b0);
    cyc(6);

    // R3: side B originates
    ext_b = 1'b1;
    cyc(SYNC);   chk("R3", pull_a, 1'b0);
    cyc(1);      chk("R3", pull_a, 1'b1);
    cyc(8);      chk("R5", pull_b, 1'b0);
    ext_b = 1'b0;
    cyc(SYNC + 1); chk("R4", pull_a, 1'b0);
    cyc(HOLD + 4);

    // R6: both low on the same cycle
    ext_a = 1'b1; ext_b = 1'b1;
    cyc(SYNC + 1); chk("R6", pull_b, 1'b1); chk("R6", pull_a, 1'b0);
    cyc(5);
    ext_a = 1'b0; ext_b = 1'b0;
    cyc(SYNC + 1 + HOLD + 4);

    // R7: side B pulled at the moment side A releases
    ext_a = 1'b1;
    cyc(SYNC + 6);
    ext_a = 1'b0; ext_b = 1'b1;
    cyc(SYNC + 1 + HOLD); chk("R7", pull_a, 1'b0);
    cyc(1);               chk("R7", pull_a, 1'b1);
    ext_b = 1'b0;
    cyc(SYNC + 1 + HOLD + 4);

    // Pseudo-random pulses on both sides, checked against the model
    begin
      int unsigned seed = 32'h1234_5678;
      for (int k = 0; k < 300; k++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        ext_a = seed[16] & seed[19];
        ext_b = seed[17] & seed[21];
        cyc(1 + int'(seed[26:24]));
      end
    end
    ext_a = 1'b0; ext_b = 1'b0;
    cyc(20);
    chk("R1", pull_a, 1'b0);
    chk("R1", pull_b, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule